// File: doc/BRIEF.md
# UART Interrupt Prioritizer

This block gathers the eight interrupt conditions of an enhanced UART and merges them into one interrupt request and one encoded status byte. The status byte names the highest-priority source that is both pending and enabled; when nothing qualifies it reads as the "nothing pending" code, whose bit 0 is set. Event-type conditions are latched. Each latched source is then cleared by its own host action: a line-status read, a holding-register read or write, a modem-status read, or a read of the status byte itself while that byte names the source. The receive-data source is a level that follows the receive FIFO trigger comparison.

The block also covers two sources that sit outside the basic set. The first is a flow-control edge source. It fires when the CTS input rises while auto-CTS is active, or when the receiver raises its RTS output while auto-RTS is active. The second is a sleep wake-up source. The FIFOs, character matching and error detection sit outside the block and deliver one-cycle event pulses or levels to it. All host strobes are one clock cycle wide.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: Priority from highest to lowest is source index 0 (line status), 1 (receive timeout), 2 (receive data), 3 (transmit ready), 4 (modem status), 5 (Xoff/special character), 6 (flow-control edge), 7 (wake-up). The status byte reads 0x06, 0x0C, 0x04, 0x02, 0x00, 0x10, 0x20 and 0x30 for these sources. Bit i of `src_en` enables source i.
- R2: `irq` is high exactly when some enabled source is pending. With none pending, `irq` is low and the status byte is 0x01. Both hold from reset.
- R3: A `line_err` pulse latches the line-status source on the next clock edge. Only `lsr_rd` clears it. A status read does not clear it.
- R4: A `rx_tout` pulse latches the receive-timeout source, and `rhr_rd` clears it.
- R5: The receive-data source is not latched. It is pending in the same cycle that `rx_trig` is high and disappears in the same cycle that `rx_trig` falls.
- R6: A `tx_empty` pulse latches the transmit-ready source. It is cleared by `thr_wr`, or by `isr_rd` in a cycle where the status byte reports transmit ready.
- R7: A `modem_chg` pulse latches the modem-status source, and `msr_rd` clears it.
- R8: A `xoff_det` pulse latches the Xoff/special source. `isr_rd` clears it only in a cycle where the status byte reports it. A status read that reports another source leaves it pending.
- R9: The flow-control edge source latches when `cts_in` goes from 0 to 1 while `auto_cts_on` is high, or when `rts_out` goes from 0 to 1 while `auto_rts_on` is high. Edges seen while the matching auto mode is off are ignored. The source is cleared by `isr_rd` while it is reported.
- R10: A `wake_up` pulse latches the wake-up source. It is cleared by `isr_rd` while it is reported.
- R11: Clearing an enable bit removes a pending source from arbitration in the same cycle but keeps it latched. Setting the bit again makes the source visible again.
- R12: If a source's set event and its clearing action occur in the same cycle, the source is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_err | input | 1 | Line error event pulse |
| rx_tout | input | 1 | Receive timeout event pulse |
| rx_trig | input | 1 | Receive FIFO at or above trigger (level) |
| tx_empty | input | 1 | Transmit FIFO empty / below trigger event pulse |
| modem_chg | input | 1 | Modem input change event pulse |
| xoff_det | input | 1 | Xoff or special character received pulse |
| cts_in | input | 1 | CTS input level, high = asserted |
| rts_out | input | 1 | RTS output level driven by the receiver, high = asserted |
| auto_cts_on | input | 1 | Auto-CTS flow control active |
| auto_rts_on | input | 1 | Auto-RTS flow control active |
| wake_up | input | 1 | Leaving sleep event pulse |
| src_en | input | 8 | Per-source enables, bit index as in R1 |
| isr_rd | input | 1 | Status byte read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| irq | output | 1 | Interrupt request |
| irq_status | output | 8 | Encoded highest-priority source |

## Verification
The hardest case to reach is a status read whose clearing effect depends on which source it reports. Several latched sources must be pending together, and the read must arrive while a lower-priority one is masked by a higher one. The stimulus pulses transmit-ready and Xoff events in the same cycle. It then issues status reads one at a time and checks that each read clears only the source currently reported. A full stack of all event sources, together with the receive level, is then drained source by source with each source's own clearing strobe. A behavioural reference model is compared against both outputs on every clock.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int NSRC = 8;
   localparam int SIDX_W = $clog2(NSRC);

   localparam int S_LINE  = 0;
   localparam int S_RXTO  = 1;
   localparam int S_RXDAT = 2;
   localparam int S_TXRDY = 3;
   localparam int S_MODEM = 4;
   localparam int S_XOFF  = 5;
   localparam int S_FLOW  = 6;
   localparam int S_WAKE  = 7;

   localparam logic [7:0] CODE_IDLE = 8'h01;

   function automatic logic [7:0] src_code(input logic [SIDX_W-1:0] s);
      logic [7:0] c;
      case (s)
         3'd0:    c = 8'h06;
         3'd1:    c = 8'h0C;
         3'd2:    c = 8'h04;
         3'd3:    c = 8'h02;
         3'd4:    c = 8'h00;
         3'd5:    c = 8'h10;
         3'd6:    c = 8'h20;
         default: c = 8'h30;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R12: a set in the same cycle as a clear leaves the flag pending
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
endmodule

// File: rtl/uirq_rise.sv
module uirq_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl;
   end

   assign rise = arm & lvl & ~prev_q;
endmodule

// File: rtl/uirq_pick.sv
module uirq_pick #(
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  act,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  grant
);
   logic [N:0] blocked;

   if (N < 2) begin : g_bad_n
      $error("uirq_pick needs at least two sources");
   end

   assign blocked[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = act[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | act[i];
   end
   assign any = blocked[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (act[i]) idx = IW'(i);
      end
   end

   // R1: at most one source wins, and it is the one named by idx
   a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (any == (grant != '0)));
   a_r1_grant_idx: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> grant[idx]);
endmodule

// File: rtl/uart_irq_prioritizer.sv
module uart_irq_prioritizer
   import uirq_pkg::*;
#(
   parameter int STAT_W = 8,
   parameter logic [NSRC-1:0] LEVEL_MASK = 8'b0000_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_err,
   input  logic              rx_tout,
   input  logic              rx_trig,
   input  logic              tx_empty,
   input  logic              modem_chg,
   input  logic              xoff_det,
   input  logic              cts_in,
   input  logic              rts_out,
   input  logic              auto_cts_on,
   input  logic              auto_rts_on,
   input  logic              wake_up,
   input  logic [NSRC-1:0]   src_en,
   input  logic              isr_rd,
   input  logic              rhr_rd,
   input  logic              thr_wr,
   input  logic              lsr_rd,
   input  logic              msr_rd,
   output logic              irq,
   output logic [STAT_W-1:0] irq_status
);
   logic [NSRC-1:0]   set_v, clr_v, pend, act, grant;
   logic [SIDX_W-1:0] win;
   logic              win_ok;
   logic              cts_rise, rts_rise;
   logic [7:0]        code;

   if (STAT_W < 6) begin : g_bad_w
      $error("irq_status must be at least 6 bits wide");
   end

   uirq_rise u_cts (.clk(clk), .rst_n(rst_n), .arm(auto_cts_on), .lvl(cts_in),  .rise(cts_rise));
   uirq_rise u_rts (.clk(clk), .rst_n(rst_n), .arm(auto_rts_on), .lvl(rts_out), .rise(rts_rise));

   assign set_v[S_LINE]  = line_err;
   assign set_v[S_RXTO]  = rx_tout;
   assign set_v[S_RXDAT] = rx_trig;
   assign set_v[S_TXRDY] = tx_empty;
   assign set_v[S_MODEM] = modem_chg;
   assign set_v[S_XOFF]  = xoff_det;
   assign set_v[S_FLOW]  = cts_rise | rts_rise;
   assign set_v[S_WAKE]  = wake_up;

   function automatic logic rd_hit(input logic ok, input logic [SIDX_W-1:0] w, input int s);
      return ok && (w == SIDX_W'(s));
   endfunction

   assign clr_v[S_LINE]  = lsr_rd;
   assign clr_v[S_RXTO]  = rhr_rd;
   assign clr_v[S_RXDAT] = 1'b0;
   assign clr_v[S_TXRDY] = thr_wr | (isr_rd & rd_hit(win_ok, win, S_TXRDY));
   assign clr_v[S_MODEM] = msr_rd;
   assign clr_v[S_XOFF]  = isr_rd & rd_hit(win_ok, win, S_XOFF);
   assign clr_v[S_FLOW]  = isr_rd & rd_hit(win_ok, win, S_FLOW);
   assign clr_v[S_WAKE]  = isr_rd & rd_hit(win_ok, win, S_WAKE);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (LEVEL_MASK[i]) begin : g_level
         assign pend[i] = set_v[i] & ~clr_v[i];
      end else begin : g_sticky
         uirq_flag u_flag (.clk(clk), .rst_n(rst_n), .set(set_v[i]), .clr(clr_v[i]), .q(pend[i]));
      end
   end

   assign act = pend & src_en;

   uirq_pick #(.N(NSRC)) u_pick (
      .clk(clk), .rst_n(rst_n), .act(act), .any(win_ok), .idx(win), .grant(grant));

   assign code       = win_ok ? src_code(win) : CODE_IDLE;
   assign irq        = win_ok;
   assign irq_status = STAT_W'(code);

   // R2: no request means the idle code is shown
   a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (irq_status == STAT_W'(CODE_IDLE)));
   // R3: a reported line-status source survives anything but lsr_rd
   a_r3_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[S_LINE] && !lsr_rd) |=> pend[S_LINE]);
   // R5: receive data is never reported once the trigger level is gone
   a_r5_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_trig |-> !grant[S_RXDAT]);
   // R6: a holding-register write clears transmit ready
   a_r6_thr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !tx_empty) |=> !pend[S_TXRDY]);
   // R9: no flow edge source can appear while both auto modes are off
   a_r9_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_cts_on && !auto_rts_on && !pend[S_FLOW]) |=> !pend[S_FLOW]);
   // R11: a masked modem source stays latched
   a_r11_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[S_MODEM] && !src_en[S_MODEM] && !msr_rd) |=> pend[S_MODEM]);
endmodule

// File: tb/uart_irq_prioritizer_test.sv
module uart_irq_prioritizer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_err = 0, rx_tout = 0, rx_trig = 0, tx_empty = 0, modem_chg = 0;
   logic xoff_det = 0, cts_in = 0, rts_out = 0, auto_cts_on = 0, auto_rts_on = 0;
   logic wake_up = 0, isr_rd = 0, rhr_rd = 0, thr_wr = 0, lsr_rd = 0, msr_rd = 0;
   logic [7:0] src_en = 8'h00;
   logic       irq;
   logic [7:0] irq_status;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   always #4 clk = ~clk;

   uart_irq_prioritizer uut (
      .clk(clk), .rst_n(rst_n), .line_err(line_err), .rx_tout(rx_tout), .rx_trig(rx_trig),
      .tx_empty(tx_empty), .modem_chg(modem_chg), .xoff_det(xoff_det), .cts_in(cts_in),
      .rts_out(rts_out), .auto_cts_on(auto_cts_on), .auto_rts_on(auto_rts_on),
      .wake_up(wake_up), .src_en(src_en), .isr_rd(isr_rd), .rhr_rd(rhr_rd),
      .thr_wr(thr_wr), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .irq(irq), .irq_status(irq_status));

   // behavioural reference model
   bit [7:0] mp;
   bit pc, pr;

   function automatic int m_winner(bit [7:0] p, bit lvl, bit [7:0] en);
      bit [7:0] e;
      e = p;
      e[2] = lvl;
      e = e & en;
      for (int i = 0; i < 8; i++) if (e[i]) return i;
      return 8;
   endfunction

   function automatic bit [7:0] m_code(int w);
      bit [7:0] t [9] = '{8'h06, 8'h0C, 8'h04, 8'h02, 8'h00, 8'h10, 8'h20, 8'h30, 8'h01};
      return t[w];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mp = '0; pc = 1; pr = 1;
      end else begin
         int  rep;
         bit [7:0] s, c;
         rep = m_winner(mp, rx_trig, src_en);
         s = {wake_up, (auto_cts_on && cts_in && !pc) || (auto_rts_on && rts_out && !pr),
              xoff_det, modem_chg, tx_empty, 1'b0, rx_tout, line_err};
         c = {isr_rd && rep == 7, isr_rd && rep == 6, isr_rd && rep == 5, msr_rd,
              thr_wr || (isr_rd && rep == 3), 1'b0, rhr_rd, lsr_rd};
         for (int i = 0; i < 8; i++) mp[i] = s[i] | (mp[i] & ~c[i]);
         pc = cts_in; pr = rts_out;
      end
   end

   always @(negedge clk) begin
      #2;
      begin
         int w;
         w = m_winner(mp, rx_trig, src_en);
         vectors++;
         if (irq_status !== m_code(w)) begin
            miscompares++;
            $display("FAIL R1 model compare: status got %h exp %h", irq_status, m_code(w));
         end
         vectors++;
         if (irq !== (w != 8)) begin
            miscompares++;
            $display("FAIL R2 model compare: irq got %b exp %b", irq, (w != 8));
         end
      end
   end

   task automatic nxt();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [7:0] exp_s, logic exp_i);
      #1;
      vectors++;
      if (irq_status !== exp_s || irq !== exp_i) begin
         miscompares++;
         $display("FAIL %s: status/irq got %h/%b exp %h/%b", tag, irq_status, irq, exp_s, exp_i);
      end
   endtask

   initial begin
      repeat (3) nxt();
      chk("R2 reset idle", 8'h01, 0);
      rst_n = 1; src_en = 8'hFF;
      nxt(); chk("R2 idle after reset", 8'h01, 0);

      // R3 line status
      line_err = 1; nxt(); line_err = 0; chk("R3 set", 8'h06, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R3 status read keeps", 8'h06, 1);
      lsr_rd = 1; nxt(); lsr_rd = 0; chk("R3 lsr read clears", 8'h01, 0);

      // R4 receive timeout
      rx_tout = 1; nxt(); rx_tout = 0; chk("R4 set", 8'h0C, 1);
      rhr_rd = 1; nxt(); rhr_rd = 0; chk("R4 rhr read clears", 8'h01, 0);

      // R5 receive data level
      rx_trig = 1; chk("R5 same cycle", 8'h04, 1);
      nxt(); rx_trig = 0; chk("R5 falls", 8'h01, 0);

      // R6 transmit ready
      tx_empty = 1; nxt(); tx_empty = 0; chk("R6 set", 8'h02, 1);
      thr_wr = 1; nxt(); thr_wr = 0; chk("R6 thr write clears", 8'h01, 0);
      tx_empty = 1; nxt(); tx_empty = 0; chk("R6 set again", 8'h02, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R6 status read clears", 8'h01, 0);

      // R7 modem
      modem_chg = 1; nxt(); modem_chg = 0; chk("R7 set", 8'h00, 1);
      msr_rd = 1; nxt(); msr_rd = 0; chk("R7 msr read clears", 8'h01, 0);

      // R8 Xoff masked by transmit ready
      xoff_det = 1; tx_empty = 1; nxt(); xoff_det = 0; tx_empty = 0;
      chk("R1 tx over xoff", 8'h02, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R8 other read keeps xoff", 8'h10, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R8 own read clears", 8'h01, 0);

      // R9 flow edges
      cts_in = 1; nxt(); chk("R9 no auto no event", 8'h01, 0);
      cts_in = 0; nxt(); auto_cts_on = 1; nxt();
      cts_in = 1; nxt(); chk("R9 cts rise", 8'h20, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R9 read clears", 8'h01, 0);
      nxt(); chk("R9 held high no refire", 8'h01, 0);
      auto_cts_on = 0; cts_in = 0; auto_rts_on = 1; nxt();
      rts_out = 1; nxt(); chk("R9 rts rise", 8'h20, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R9 rts read clears", 8'h01, 0);
      auto_rts_on = 0; rts_out = 0;

      // R10 wake-up
      wake_up = 1; nxt(); wake_up = 0; chk("R10 set", 8'h30, 1);
      isr_rd = 1; nxt(); isr_rd = 0; chk("R10 read clears", 8'h01, 0);

      // R11 masking keeps the latch
      src_en[4] = 0; modem_chg = 1; nxt(); modem_chg = 0; chk("R11 masked", 8'h01, 0);
      repeat (3) nxt();
      src_en = 8'hFF; chk("R11 re-enabled", 8'h00, 1);
      msr_rd = 1; nxt(); msr_rd = 0; chk("R11 cleared", 8'h01, 0);

      // R12 set beats clear
      line_err = 1; nxt(); chk("R12 set", 8'h06, 1);
      lsr_rd = 1; nxt(); line_err = 0; lsr_rd = 0; chk("R12 set wins", 8'h06, 1);
      lsr_rd = 1; nxt(); lsr_rd = 0; chk("R12 then clears", 8'h01, 0);

      // R1 full stack drained in order
      line_err = 1; rx_tout = 1; tx_empty = 1; modem_chg = 1; xoff_det = 1; wake_up = 1;
      rx_trig = 1; nxt();
      line_err = 0; rx_tout = 0; tx_empty = 0; modem_chg = 0; xoff_det = 0; wake_up = 0;
      chk("R1 line first", 8'h06, 1);
      lsr_rd = 1; nxt(); lsr_rd = 0; chk("R1 timeout next", 8'h0C, 1);
      rhr_rd = 1; nxt(); rhr_rd = 0; chk("R1 rx data next", 8'h04, 1);
      rx_trig = 0; chk("R1 tx next", 8'h02, 1);
      thr_wr = 1; nxt(); thr_wr = 0; chk("R1 modem next", 8'h00, 1);
      msr_rd = 1; nxt(); msr_rd = 0; chk("R1 xoff next", 8'h10, 1);
      isr_rd = 1; nxt(); chk("R1 wake next", 8'h30, 1);
      nxt(); isr_rd = 0; chk("R1 drained", 8'h01, 0);

      repeat (4) nxt();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule